// File: doc/BRIEF.md
# Move-Transport Processor Core

This block is a tiny processor whose program consists only of data transports. Every instruction word is split into two move slots, one per transport bus. Each slot picks one value source (a register, the adder/subtractor result, its own constant field or an external input pin) and one sink (a register, the unit's operand latch, one of its two trigger ports or an output register). Arithmetic is never requested directly. Writing a trigger port makes the unit combine the value arriving there with its operand latch.

The program store is a register array inside the core. It has a write port that can load words at any time, including while execution is frozen. On every cycle in which the lock input is low, the core executes the word at the program counter and then advances the counter. When lock is high, the counter and every sink keep their values. This lets a driver step the core one word at a time.

Top module: `mt_core`

## Requirements
- R1: After an asynchronous active-low reset, the program counter, output register, all four registers, the operand latch and the result register read zero, and every program word is a no-op.
- R2: In every cycle with lock low, the word at the program counter is executed and the counter advances by one, wrapping from IM_DEPTH-1 to 0.
- R3: A slot is 17 bits: bit 16 valid, bits 15:12 source id, bits 11:8 sink id, bits 7:0 constant. Slot 0 occupies word bits 16:0 and slot 1 occupies bits 33:17. A slot with valid clear moves nothing.
- R4: Source ids are as follows: 0-3 read the register of that index, 4 reads the result register, 5 reads the slot constant zero-extended, 6 reads din_i, and every other id reads zero.
- R5: Sink ids are as follows: 0-3 write the register of that index, 4 writes the operand latch, 5 is the add trigger, 6 is the subtract trigger, 7 writes the output register dout_o, and every other id discards the value.
- R6: A trigger sets the result register to operand+value (id 5) or operand-value (id 6), modulo 2^DW. The new result is readable by the next executed word.
- R7: If an operand write and a trigger come in the same word, the trigger uses the newly written operand.
- R8: Every source of a word is read before any sink of that word is written. For example, moves r0->r1 and r1->r0 in one word swap the two registers.
- R9: The result register can feed the operand latch or a trigger port directly, without going through a register.
- R10: When both slots of one word write the same sink, slot 1 wins. When both slots hit trigger ports, slot 1's trigger defines the operation.
- R11: While lock_i is high, the program counter and all sinks hold their values.
- R12: A program write (imem_we_i) stores imem_wdata_i at imem_addr_i on the clock edge, whether or not lock is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Freeze counter and all sinks |
| imem_we_i | input | 1 | Program store write enable |
| imem_addr_i | input | 4 | Program store write address |
| imem_wdata_i | input | 34 | Program word to store |
| din_i | input | 8 | External value, source id 6 |
| pc_o | output | 4 | Program counter |
| dout_o | output | 8 | Output register, sink id 7 |

## Verification
The two buses can land in the same cycle in several ways: an operand write together with a trigger, two moves into one sink, a swap between registers, and add and subtract triggers issued together. The bench provokes each case with single-stepped words, written at the current counter while lock is high and then released for exactly one cycle. It judges each case by moving the affected value to dout_o in the next word and comparing it with a value computed arithmetically in the bench. Add and subtract are swept over a 16x16 grid of operands to cover the same-cycle operand-and-trigger path.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int NUM_SLOTS = 2;
  localparam int ID_W      = 4;
  localparam int IMM_W     = 8;
  localparam int NREG      = 4;
  localparam int RA_W      = $clog2(NREG);

  typedef struct packed {
    logic             valid;
    logic [ID_W-1:0]  src;
    logic [ID_W-1:0]  dst;
    logic [IMM_W-1:0] imm;
  } slot_t;

  localparam int SLOT_W = $bits(slot_t);
  localparam int WORD_W = NUM_SLOTS * SLOT_W;

  // source ids
  localparam logic [ID_W-1:0] SRC_RES = 4'd4;
  localparam logic [ID_W-1:0] SRC_IMM = 4'd5;
  localparam logic [ID_W-1:0] SRC_DIN = 4'd6;
  // sink ids
  localparam logic [ID_W-1:0] DST_OPND = 4'd4;
  localparam logic [ID_W-1:0] DST_ADD  = 4'd5;
  localparam logic [ID_W-1:0] DST_SUB  = 4'd6;
  localparam logic [ID_W-1:0] DST_OUT  = 4'd7;
endpackage

// File: rtl/mt_fetch.sv
module mt_fetch #(
  parameter int IM_DEPTH = 16,
  parameter int WORD_W   = 34,
  localparam int PC_W    = $clog2(IM_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              we_i,
  input  logic [PC_W-1:0]   waddr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [WORD_W-1:0] word_o
);
  logic [WORD_W-1:0] mem_q [IM_DEPTH];
  logic [PC_W-1:0]   pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < IM_DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pc_q <= '0;
    else if (!lock_i) pc_q <= (pc_q == PC_W'(IM_DEPTH - 1)) ? '0 : pc_q + 1'b1;
  end

  assign pc_o   = pc_q;
  assign word_o = mem_q[pc_q];
endmodule

// File: rtl/mt_src_mux.sv
module mt_src_mux #(
  parameter int DW = 8
) (
  input  mt_pkg::slot_t slot_i,
  input  logic [DW-1:0] rf_rd_i,
  input  logic [DW-1:0] res_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] bus_o
);
  import mt_pkg::*;

  always_comb begin
    if (slot_i.src < ID_W'(NREG)) bus_o = rf_rd_i;
    else begin
      unique case (slot_i.src)
        SRC_RES: bus_o = res_i;
        SRC_IMM: bus_o = DW'(slot_i.imm);
        SRC_DIN: bus_o = din_i;
        default: bus_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mt_route.sv
module mt_route #(
  parameter int DW = 8
) (
  input  mt_pkg::slot_t [mt_pkg::NUM_SLOTS-1:0]              slots_i,
  input  logic [mt_pkg::NUM_SLOTS-1:0][DW-1:0]               bus_i,
  input  logic                                               lock_i,
  output logic [mt_pkg::NUM_SLOTS-1:0]                       rf_we_o,
  output logic [mt_pkg::NUM_SLOTS-1:0][mt_pkg::RA_W-1:0]     rf_waddr_o,
  output logic [mt_pkg::NUM_SLOTS-1:0][DW-1:0]               rf_wdata_o,
  output logic                                               opnd_we_o,
  output logic [DW-1:0]                                      opnd_d_o,
  output logic                                               trig_we_o,
  output logic                                               trig_sub_o,
  output logic [DW-1:0]                                      trig_d_o,
  output logic                                               out_we_o,
  output logic [DW-1:0]                                      out_d_o
);
  import mt_pkg::*;

  // ascending slot order: later assignment wins, so the higher slot has priority
  always_comb begin
    rf_we_o    = '0;
    opnd_we_o  = 1'b0;
    opnd_d_o   = '0;
    trig_we_o  = 1'b0;
    trig_sub_o = 1'b0;
    trig_d_o   = '0;
    out_we_o   = 1'b0;
    out_d_o    = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      rf_waddr_o[k] = slots_i[k].dst[RA_W-1:0];
      rf_wdata_o[k] = bus_i[k];
      if (slots_i[k].valid && !lock_i) begin
        if (slots_i[k].dst < ID_W'(NREG)) rf_we_o[k] = 1'b1;
        else begin
          unique case (slots_i[k].dst)
            DST_OPND: begin opnd_we_o = 1'b1; opnd_d_o = bus_i[k]; end
            DST_ADD:  begin trig_we_o = 1'b1; trig_sub_o = 1'b0; trig_d_o = bus_i[k]; end
            DST_SUB:  begin trig_we_o = 1'b1; trig_sub_o = 1'b1; trig_d_o = bus_i[k]; end
            DST_OUT:  begin out_we_o = 1'b1; out_d_o = bus_i[k]; end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mt_regfile.sv
module mt_regfile #(
  parameter int DW     = 8,
  parameter int NREG   = 4,
  parameter int NPORT  = 2,
  localparam int RA_W  = $clog2(NREG)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NPORT-1:0][RA_W-1:0]  raddr_i,
  output logic [NPORT-1:0][DW-1:0]    rdata_o,
  input  logic [NPORT-1:0]            we_i,
  input  logic [NPORT-1:0][RA_W-1:0]  waddr_i,
  input  logic [NPORT-1:0][DW-1:0]    wdata_i
);
  logic [DW-1:0] rf_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) rf_q[i] <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++)
        if (we_i[p]) rf_q[waddr_i[p]] <= wdata_i[p];
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    assign rdata_o[p] = rf_q[raddr_i[p]];
  end
endmodule

// File: rtl/mt_addsub.sv
module mt_addsub #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          opnd_we_i,
  input  logic [DW-1:0] opnd_d_i,
  input  logic          trig_we_i,
  input  logic          trig_sub_i,
  input  logic [DW-1:0] trig_d_i,
  output logic [DW-1:0] res_o
);
  logic [DW-1:0] opnd_q, res_q, opnd_eff;

  // a same-word operand write is seen by the trigger
  assign opnd_eff = opnd_we_i ? opnd_d_i : opnd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opnd_q <= '0;
      res_q  <= '0;
    end else begin
      if (opnd_we_i) opnd_q <= opnd_d_i;
      if (trig_we_i) res_q  <= trig_sub_i ? opnd_eff - trig_d_i : opnd_eff + trig_d_i;
    end
  end

  assign res_o = res_q;
endmodule

// File: rtl/mt_core.sv
module mt_core #(
  parameter int DW       = 8,
  parameter int IM_DEPTH = 16,
  localparam int PC_W    = $clog2(IM_DEPTH),
  localparam int WORD_W  = mt_pkg::WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lock_i,
  input  logic              imem_we_i,
  input  logic [PC_W-1:0]   imem_addr_i,
  input  logic [WORD_W-1:0] imem_wdata_i,
  input  logic [DW-1:0]     din_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [DW-1:0]     dout_o
);
  import mt_pkg::*;

  logic [WORD_W-1:0]                  word;
  slot_t [NUM_SLOTS-1:0]              slots;
  logic [NUM_SLOTS-1:0][RA_W-1:0]     rf_raddr;
  logic [NUM_SLOTS-1:0][DW-1:0]       rf_rdata, bus;
  logic [NUM_SLOTS-1:0]               rf_we;
  logic [NUM_SLOTS-1:0][RA_W-1:0]     rf_waddr;
  logic [NUM_SLOTS-1:0][DW-1:0]       rf_wdata;
  logic                               opnd_we, trig_we, trig_sub, out_we;
  logic [DW-1:0]                      opnd_d, trig_d, out_d, res_q, dout_q;

  mt_fetch #(.IM_DEPTH(IM_DEPTH), .WORD_W(WORD_W)) u_fetch (
    .clk_i, .rst_ni, .lock_i,
    .we_i(imem_we_i), .waddr_i(imem_addr_i), .wdata_i(imem_wdata_i),
    .pc_o, .word_o(word)
  );

  assign slots = word;

  // one register read port per bus
  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_bus
    assign rf_raddr[k] = slots[k].src[RA_W-1:0];
    mt_src_mux #(.DW(DW)) u_mux (
      .slot_i(slots[k]), .rf_rd_i(rf_rdata[k]), .res_i(res_q),
      .din_i, .bus_o(bus[k])
    );
  end

  mt_regfile #(.DW(DW), .NREG(NREG), .NPORT(NUM_SLOTS)) u_rf (
    .clk_i, .rst_ni, .raddr_i(rf_raddr), .rdata_o(rf_rdata),
    .we_i(rf_we), .waddr_i(rf_waddr), .wdata_i(rf_wdata)
  );

  mt_route #(.DW(DW)) u_route (
    .slots_i(slots), .bus_i(bus), .lock_i,
    .rf_we_o(rf_we), .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata),
    .opnd_we_o(opnd_we), .opnd_d_o(opnd_d),
    .trig_we_o(trig_we), .trig_sub_o(trig_sub), .trig_d_o(trig_d),
    .out_we_o(out_we), .out_d_o(out_d)
  );

  mt_addsub #(.DW(DW)) u_fu (
    .clk_i, .rst_ni, .opnd_we_i(opnd_we), .opnd_d_i(opnd_d),
    .trig_we_i(trig_we), .trig_sub_i(trig_sub), .trig_d_i(trig_d), .res_o(res_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     dout_q <= '0;
    else if (out_we) dout_q <= out_d;
  end

  assign dout_o = dout_q;
endmodule

// File: rtl/mt_core_chk.sv
module mt_core_chk #(
  parameter int DW       = 8,
  parameter int IM_DEPTH = 16,
  localparam int PC_W    = $clog2(IM_DEPTH),
  localparam int WORD_W  = mt_pkg::WORD_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lock_i,
  input logic [PC_W-1:0]   pc_o,
  input logic [DW-1:0]     dout_o,
  input logic [WORD_W-1:0] word,
  input logic [DW-1:0]     res_q
);
  import mt_pkg::*;

  function automatic logic hits(input logic [WORD_W-1:0] w,
                                input logic [ID_W-1:0] a, input logic [ID_W-1:0] b);
    slot_t s;
    hits = 1'b0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      s = w[k*SLOT_W +: SLOT_W];
      if (s.valid && (s.dst == a || s.dst == b)) hits = 1'b1;
    end
  endfunction

  p_pc_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(pc_o));

  p_pc_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> pc_o == (($past(pc_o) == PC_W'(IM_DEPTH - 1)) ? '0 : $past(pc_o) + 1'b1));

  p_out_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_i |=> $stable(dout_o));

  p_out_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dout_o) |-> $past(!lock_i && hits(word, DST_OUT, DST_OUT)));

  p_res_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(res_q) |-> $past(!lock_i && hits(word, DST_ADD, DST_SUB)));
endmodule

bind mt_core mt_core_chk #(.DW(DW), .IM_DEPTH(IM_DEPTH)) u_chk (
  .clk_i, .rst_ni, .lock_i, .pc_o, .dout_o, .word(word), .res_q(res_q)
);

// File: tb/mt_core_bench.sv
module mt_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int IM_DEPTH = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lock_i = 1'b1;
  logic        imem_we_i = 1'b0;
  logic [3:0]  imem_addr_i = '0;
  logic [33:0] imem_wdata_i = '0;
  logic [7:0]  din_i = '0;
  logic [3:0]  pc_o;
  logic [7:0]  dout_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mt_core #(.DW(DW), .IM_DEPTH(IM_DEPTH)) u_mt_core (
    .clk_i, .rst_ni, .lock_i, .imem_we_i, .imem_addr_i, .imem_wdata_i,
    .din_i, .pc_o, .dout_o
  );

  function automatic logic [16:0] sl(input bit v, input int src, input int dst, input int imm);
    return {v, 4'(src), 4'(dst), 8'(imm)};
  endfunction

  localparam logic [16:0] NOP = '0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // store word at current pc while locked, then release lock for one edge
  task automatic exec(input logic [16:0] s1, input logic [16:0] s0);
    @(negedge clk_i);
    lock_i = 1'b1; imem_we_i = 1'b1; imem_addr_i = pc_o; imem_wdata_i = {s1, s0};
    @(negedge clk_i);
    imem_we_i = 1'b0; lock_i = 1'b0;
    @(negedge clk_i);
    lock_i = 1'b1;
  endtask

  task automatic show(input int src);
    exec(NOP, sl(1, src, 7, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    check("R1 pc", pc_o, 0);
    check("R1 dout", dout_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    show(4); check("R1 result", dout_o, 0);
    for (int r = 0; r < 4; r++) begin show(r); check("R1 reg", dout_o, 0); end

    // R6 R7: operand and trigger in one word, add and sub sweep
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        int av = (a * 37 + 5) % 256;
        int bv = (b * 53 + 11) % 256;
        exec(sl(1, 5, 5, bv), sl(1, 5, 4, av));
        show(4); check("R7 add", dout_o, (av + bv) % 256);
        exec(sl(1, 5, 6, bv), sl(1, 5, 4, av));
        show(4); check("R6 sub", dout_o, (av - bv + 256) % 256);
      end

    // R4 R5: every register written and read back
    for (int r = 0; r < 4; r++) exec(NOP, sl(1, 5, r, 8'h30 + r));
    for (int r = 0; r < 4; r++) begin show(r); check("R5 reg", dout_o, 8'h30 + r); end

    // R8: swap r0 and r1 in one word
    exec(sl(1, 1, 0, 0), sl(1, 0, 1, 0));
    show(0); check("R8 r0", dout_o, 8'h31);
    show(1); check("R8 r1", dout_o, 8'h30);

    // R4: external input and undefined source
    din_i = 8'h5A;
    exec(sl(1, 6, 7, 0), NOP); check("R4 din", dout_o, 8'h5A);
    exec(sl(1, 9, 7, 8'hFF), NOP); check("R4 undef src", dout_o, 0);

    // R3: invalid slot moves nothing
    exec(sl(1, 5, 7, 8'h44), NOP);
    exec(sl(0, 5, 7, 8'h77), sl(0, 5, 2, 8'h77));
    check("R3 out", dout_o, 8'h44);
    show(2); check("R3 reg", dout_o, 8'h32);
    // R5: undefined sink discards
    exec(sl(1, 5, 7, 8'h45), NOP);
    exec(sl(1, 5, 12, 8'h99), sl(1, 5, 15, 8'h98));
    check("R5 undef sink", dout_o, 8'h45);
    show(3); check("R5 undef reg", dout_o, 8'h33);

    // R10: same sink, slot 1 wins
    exec(sl(1, 5, 7, 8'h20), sl(1, 5, 7, 8'h10)); check("R10 out", dout_o, 8'h20);
    exec(sl(1, 5, 2, 2), sl(1, 5, 2, 1));
    show(2); check("R10 reg", dout_o, 2);
    exec(NOP, sl(1, 5, 4, 50));
    exec(sl(1, 5, 6, 3), sl(1, 5, 5, 5));
    show(4); check("R10 trig sub", dout_o, 47);
    exec(sl(1, 5, 5, 3), sl(1, 5, 6, 5));
    show(4); check("R10 trig add", dout_o, 53);

    // R9: result feeds trigger and operand directly
    exec(sl(1, 5, 5, 7), sl(1, 5, 4, 100));
    exec(NOP, sl(1, 4, 5, 0));
    show(4); check("R9 res->trig", dout_o, 207);
    exec(sl(1, 5, 6, 7), sl(1, 4, 4, 0));
    show(4); check("R9 res->opnd", dout_o, 200);

    // R11: lock holds pc and sinks; R12: program write while locked
    begin
      int p0;
      exec(NOP, sl(1, 5, 7, 8'h66));
      @(negedge clk_i);
      p0 = pc_o;
      imem_we_i = 1'b1; imem_addr_i = pc_o; imem_wdata_i = {NOP, sl(1, 5, 7, 8'h11)};
      @(negedge clk_i); imem_we_i = 1'b0;
      repeat (8) @(negedge clk_i);
      check("R11 pc", pc_o, p0);
      check("R11 dout", dout_o, 8'h66);
      lock_i = 1'b0; @(negedge clk_i); lock_i = 1'b1;
      check("R12 stored word", dout_o, 8'h11);
      check("R2 pc step", pc_o, (p0 + 1) % IM_DEPTH);
    end

    // R2: free run with wrap; each word does result+1 via result->operand
    begin
      int p0;
      exec(sl(1, 5, 5, 0), sl(1, 5, 4, 0));
      @(negedge clk_i);
      p0 = pc_o;
      for (int i = 0; i < IM_DEPTH; i++) begin
        imem_we_i = 1'b1; imem_addr_i = 4'(i); imem_wdata_i = {sl(1, 5, 5, 1), sl(1, 4, 4, 0)};
        @(negedge clk_i);
      end
      imem_we_i = 1'b0;
      lock_i = 1'b0;
      repeat (20) @(negedge clk_i);
      lock_i = 1'b1;
      check("R2 wrap pc", pc_o, (p0 + 20) % IM_DEPTH);
      show(4); check("R2 run count", dout_o, 20);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule